// File: doc/BRIEF.md
# Per-Epoch Pair Traffic Ranker

This block watches the packet injection stream of a network and keeps one counter for every ordered source/destination pair of nodes. It does not count per node or per link. Each accepted epoch tick closes the running epoch. The ranker then walks the frozen counters of that epoch and builds a sorted list of the K busiest pairs. It hands the list to a topology reconfiguration controller over a valid/ready stream, busiest pair first.

The counters live in two banks that swap roles at each accepted tick. The bank that just closed is scanned one address per clock. Each address is zeroed as it is read, so the bank is clean when it becomes the counting bank again. Counting in the other bank continues without a break. After reset, one sweep of 2^(2·NODE_W) clocks zeroes both banks before counting starts.

Top module: `pair_traffic_ranker`

## Requirements
- R1: Each cycle with `pkt_valid` high and `pkt_src` different from `pkt_dst` adds one to the counter of pair (`pkt_src`, `pkt_dst`). This holds for packets in consecutive cycles, including the same pair repeated on every cycle.
- R2: A packet whose source equals its destination is not counted, and such a pair is never reported.
- R3: A counter that has reached 2^CNT_W-1 stays at that value on further packets and does not wrap.
- R4: A tick taken in the idle phase closes the epoch. A packet presented in the same cycle as that tick counts toward the new epoch. Every epoch starts with all counters at zero.
- R5: After an epoch closes, up to K pairs with a nonzero count are reported, in descending count order. Equal counts are ordered by ascending pair index, where the index is `pkt_src`·2^NODE_W + `pkt_dst`. Pairs beyond the K-th are dropped. `out_last` is high on the final entry only. An epoch with no counted packets reports nothing.
- R6: While `out_valid` is high and `out_ready` is low, the presented entry and `out_last` hold steady.
- R7: With `out_ready` low, `out_valid` first rises exactly 2^(2·NODE_W)+1 rising edges after the edge that samples the accepted tick.
- R8: A tick that arrives while a scan or an output list is still pending has no effect. Packets in that time are counted toward the epoch that is running.
- R9: `out_valid` is low during reset. For 2^(2·NODE_W) cycles after reset, packets and ticks are ignored while both banks are zeroed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Packet injection strobe |
| pkt_src | input | NODE_W | Source node of the packet |
| pkt_dst | input | NODE_W | Destination node of the packet |
| epoch_tick | input | 1 | Request to close the running epoch |
| out_ready | input | 1 | Consumer accepts the presented entry |
| out_valid | output | 1 | A ranked entry is presented |
| out_src | output | NODE_W | Source node of the presented pair |
| out_dst | output | NODE_W | Destination node of the presented pair |
| out_cnt | output | CNT_W | Packet count of the presented pair |
| out_last | output | 1 | Presented entry is the final one of the list |

## Verification
Counting has no visible latency of its own. Its effect shows only in the list, whose first entry appears 2^(2·NODE_W)+1 edges after the tick edge. The bench measures that gap edge by edge with `out_ready` held low. It then accepts one entry per edge and samples one time unit after each edge, when every registered output has settled. For an empty epoch, the bench watches the full scan window plus margin and checks that `out_valid` never rises. For back-pressure, it re-samples the held entry on every stalled edge before it raises `out_ready`.

// File: rtl/prt_pkg.sv
package prt_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_SCAN,
    ST_FLUSH,
    ST_EMIT
  } prt_state_e;

endpackage

// File: rtl/prt_count_bank.sv
module prt_count_bank #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // one read port and one write port, read returns the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/prt_topk.sv
module prt_topk #(
  parameter int CNT_W = 16,
  parameter int KEY_W = 12,
  parameter int K     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ins_vld,
  input  logic [CNT_W-1:0] ins_cnt,
  input  logic [KEY_W-1:0] ins_key,
  input  logic             pop,
  output logic             head_vld,
  output logic [CNT_W-1:0] head_cnt,
  output logic [KEY_W-1:0] head_key,
  output logic             head_last
);
  typedef struct packed {
    logic             vld;
    logic [CNT_W-1:0] cnt;
    logic [KEY_W-1:0] key;
  } ent_t;

  ent_t           lst [K];
  ent_t           nxt [K];
  ent_t           cand;
  logic [K-1:0]   beat;

  assign cand = '{vld: 1'b1, cnt: ins_cnt, key: ins_key};

  // keys arrive in ascending order, so an equal count never displaces
  always_comb begin
    for (int i = 0; i < K; i++) begin
      beat[i] = !lst[i].vld || (ins_cnt > lst[i].cnt);
    end
    nxt[0] = beat[0] ? cand : lst[0];
    for (int i = 1; i < K; i++) begin
      if (!beat[i])          nxt[i] = lst[i];
      else if (beat[i-1])    nxt[i] = lst[i-1];
      else                   nxt[i] = cand;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < K; i++) lst[i] <= '0;
    end else if (ins_vld) begin
      for (int i = 0; i < K; i++) lst[i] <= nxt[i];
    end else if (pop) begin
      for (int i = 0; i < K - 1; i++) lst[i] <= lst[i+1];
      lst[K-1] <= '0;
    end
  end

  assign head_vld = lst[0].vld;
  assign head_cnt = lst[0].cnt;
  assign head_key = lst[0].key;

  generate
    if (K == 1) begin : g_single
      assign head_last = lst[0].vld;
    end else begin : g_multi
      assign head_last = lst[0].vld && !lst[1].vld;
    end
  endgenerate

  // R5: stored list stays ordered by count, then by ascending key
  generate
    for (genvar i = 0; i < K - 1; i++) begin : g_ord
      a_r5_order: assert property (@(posedge clk) disable iff (rst)
        lst[i+1].vld |-> (lst[i].vld &&
          ((lst[i].cnt > lst[i+1].cnt) ||
           ((lst[i].cnt == lst[i+1].cnt) && (lst[i].key < lst[i+1].key)))));
    end
  endgenerate

endmodule

// File: rtl/pair_traffic_ranker.sv
module pair_traffic_ranker #(
  parameter int NODE_W = 6,
  parameter int CNT_W  = 16,
  parameter int K      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_valid,
  input  logic [NODE_W-1:0] pkt_src,
  input  logic [NODE_W-1:0] pkt_dst,
  input  logic              epoch_tick,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [NODE_W-1:0] out_src,
  output logic [NODE_W-1:0] out_dst,
  output logic [CNT_W-1:0]  out_cnt,
  output logic              out_last
);
  import prt_pkg::*;

  localparam int AW = 2 * NODE_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  prt_state_e       st;
  logic             act_bank;
  logic [AW-1:0]    idx;

  logic             tick_acc;
  logic             p0_vld;
  logic             p0_bank;
  logic [AW-1:0]    p0_addr;
  logic             snap_bank;

  logic             s1_vld;
  logic             s1_bank;
  logic [AW-1:0]    s1_addr;
  logic [CNT_W-1:0] cur;
  logic [CNT_W-1:0] inc_val;

  logic             wb_vld;
  logic             wb_bank;
  logic [AW-1:0]    wb_addr;
  logic [CNT_W-1:0] wb_val;

  logic             sc_vld;
  logic [AW-1:0]    sc_key;

  logic [CNT_W-1:0] q [2];

  logic             head_vld;
  logic [CNT_W-1:0] head_cnt;
  logic [AW-1:0]    head_key;
  logic             head_last;
  logic             pop;

  assign tick_acc  = epoch_tick && (st == ST_IDLE);
  assign p0_vld    = pkt_valid && (pkt_src != pkt_dst) && (st != ST_INIT);
  assign p0_bank   = act_bank ^ tick_acc;
  assign p0_addr   = {pkt_src, pkt_dst};
  assign snap_bank = ~act_bank;

  // counter banks: one counts, the other is scanned and zeroed
  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      localparam logic BK = 1'(b);
      logic             rd_pkt;
      logic             wr_pkt;
      logic             scan_here;
      logic             re;
      logic             we;
      logic [AW-1:0]    raddr;
      logic [AW-1:0]    waddr;
      logic [CNT_W-1:0] wdata;

      assign rd_pkt    = p0_vld && (p0_bank == BK);
      assign wr_pkt    = s1_vld && (s1_bank == BK);
      assign scan_here = (st == ST_SCAN) && (snap_bank == BK);
      assign re        = rd_pkt || scan_here;
      assign raddr     = rd_pkt ? p0_addr : idx;
      assign we        = wr_pkt || scan_here || (st == ST_INIT);
      assign waddr     = wr_pkt ? s1_addr : idx;
      assign wdata     = wr_pkt ? inc_val : '0;

      prt_count_bank #(.AW(AW), .DW(CNT_W)) i_bank (
        .clk   (clk),
        .re    (re),
        .raddr (raddr),
        .rdata (q[b]),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata)
      );
    end
  endgenerate

  // read-modify-write with one-deep bypass for back-to-back hits
  always_comb begin
    if (wb_vld && (wb_bank == s1_bank) && (wb_addr == s1_addr)) cur = wb_val;
    else                                                        cur = q[s1_bank];
    inc_val = (cur == CMAX) ? cur : cur + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      wb_vld <= 1'b0;
    end else begin
      s1_vld <= p0_vld;
      wb_vld <= s1_vld;
    end
    s1_bank <= p0_bank;
    s1_addr <= p0_addr;
    wb_bank <= s1_bank;
    wb_addr <= s1_addr;
    wb_val  <= inc_val;
  end

  // phase control
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_INIT;
      idx      <= '0;
      act_bank <= 1'b0;
      sc_vld   <= 1'b0;
    end else begin
      sc_vld <= (st == ST_SCAN);
      unique case (st)
        ST_INIT: begin
          idx <= idx + 1'b1;
          if (idx == AW'((1 << AW) - 1)) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (tick_acc) begin
            act_bank <= ~act_bank;
            idx      <= '0;
            st       <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          idx <= idx + 1'b1;
          if (idx == AW'((1 << AW) - 1)) st <= ST_FLUSH;
        end
        ST_FLUSH: st <= ST_EMIT;
        ST_EMIT: begin
          if (!head_vld || (out_ready && head_last)) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
    sc_key <= idx;
  end

  assign pop = out_valid && out_ready;

  prt_topk #(.CNT_W(CNT_W), .KEY_W(AW), .K(K)) i_topk (
    .clk       (clk),
    .rst       (rst),
    .clr       (tick_acc),
    .ins_vld   (sc_vld && (q[snap_bank] != '0)),
    .ins_cnt   (q[snap_bank]),
    .ins_key   (sc_key),
    .pop       (pop),
    .head_vld  (head_vld),
    .head_cnt  (head_cnt),
    .head_key  (head_key),
    .head_last (head_last)
  );

  assign out_valid = (st == ST_EMIT) && head_vld;
  assign out_src   = head_key[AW-1:NODE_W];
  assign out_dst   = head_key[NODE_W-1:0];
  assign out_cnt   = head_cnt;
  assign out_last  = head_last;

  // R6: a stalled entry holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cnt) &&
      $stable(out_src) && $stable(out_dst) && $stable(out_last)));

  // R5: only nonzero counts leave the block
  a_r5_nonzero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cnt != '0));

  // R2: self pairs never reach the output
  a_r2_no_self: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_src != out_dst));

  // R3: the written count never wraps below the value it replaces
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> ((inc_val >= cur) && (inc_val != '0)));

  // R8: a tick outside the idle phase leaves the bank roles alone
  a_r8_tick_ignored: assert property (@(posedge clk) disable iff (rst)
    (epoch_tick && (st != ST_IDLE)) |=> $stable(act_bank));

  // R9: nothing enters the count pipeline during the clearing sweep
  a_r9_init_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INIT) |=> !s1_vld);

endmodule

// File: tb/test_pair_traffic_ranker.sv
module test_pair_traffic_ranker;
  localparam int NW = 3;
  localparam int CW = 4;
  localparam int KK = 4;
  localparam int NP = 1 << (2 * NW);
  localparam int CMAXI = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pkt_valid = 1'b0;
  logic [NW-1:0] pkt_src = '0;
  logic [NW-1:0] pkt_dst = '0;
  logic          epoch_tick = 1'b0;
  logic          out_ready = 1'b0;
  logic          out_valid;
  logic [NW-1:0] out_src;
  logic [NW-1:0] out_dst;
  logic [CW-1:0] out_cnt;
  logic          out_last;

  int n_chk  = 0;
  int n_fail = 0;
  int mdl  [NP];
  int snap [NP];
  int exp_key [KK];
  int exp_cnt [KK];
  int n_exp;

  always #10 clk = ~clk;

  pair_traffic_ranker #(.NODE_W(NW), .CNT_W(CW), .K(KK)) i_pair_traffic_ranker (
    .clk        (clk),
    .rst        (rst),
    .pkt_valid  (pkt_valid),
    .pkt_src    (pkt_src),
    .pkt_dst    (pkt_dst),
    .epoch_tick (epoch_tick),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_src    (out_src),
    .out_dst    (out_dst),
    .out_cnt    (out_cnt),
    .out_last   (out_last)
  );

  task automatic chk(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic count_model(int s, int d);
    if (s != d && mdl[s * (1 << NW) + d] < CMAXI) mdl[s * (1 << NW) + d]++;
  endtask

  task automatic send(int s, int d, int n);
    for (int i = 0; i < n; i++) begin
      pkt_valid = 1'b1;
      pkt_src   = s[NW-1:0];
      pkt_dst   = d[NW-1:0];
      count_model(s, d);
      step();
    end
    pkt_valid = 1'b0;
  endtask

  task automatic tick(bit with_pkt, int s, int d);
    epoch_tick = 1'b1;
    snap = mdl;
    foreach (mdl[i]) mdl[i] = 0;
    if (with_pkt) begin
      pkt_valid = 1'b1;
      pkt_src   = s[NW-1:0];
      pkt_dst   = d[NW-1:0];
      count_model(s, d);
    end
    step();
    epoch_tick = 1'b0;
    pkt_valid  = 1'b0;
  endtask

  task automatic ign_tick();
    epoch_tick = 1'b1;
    step();
    epoch_tick = 1'b0;
  endtask

  task automatic build_exp();
    bit used [NP];
    foreach (used[i]) used[i] = 1'b0;
    n_exp = 0;
    for (int e = 0; e < KK; e++) begin
      int best = 0;
      int bi = -1;
      for (int i = 0; i < NP; i++) begin
        if (!used[i] && snap[i] > best) begin
          best = snap[i];
          bi = i;
        end
      end
      if (bi >= 0) begin
        used[bi] = 1'b1;
        exp_key[n_exp] = bi;
        exp_cnt[n_exp] = best;
        n_exp++;
      end
    end
  endtask

  task automatic drain(int hold, string req);
    int w;
    int seen;
    int k0;
    build_exp();
    if (n_exp == 0) begin
      out_ready = 1'b1;
      seen = 0;
      repeat (NP + 10) begin
        step();
        if (out_valid) seen = 1;
      end
      chk(req, "output on empty epoch", seen, 0);
      out_ready = 1'b0;
      return;
    end
    out_ready = (hold == 0);
    w = 0;
    while (!out_valid && w < NP + 20) begin
      step();
      w++;
    end
    chk(req, "result list present", int'(out_valid), 1);
    if (hold > 0) begin
      k0 = int'({out_src, out_dst});
      repeat (hold) begin
        step();
        chk("R6", "stalled valid", int'(out_valid), 1);
        chk("R6", "stalled pair", int'({out_src, out_dst}), k0);
        chk("R6", "stalled last", int'(out_last), (n_exp == 1) ? 1 : 0);
      end
      out_ready = 1'b1;
    end
    for (int e = 0; e < n_exp; e++) begin
      chk(req, "entry valid", int'(out_valid), 1);
      chk(req, "entry pair", int'({out_src, out_dst}), exp_key[e]);
      chk(req, "entry count", int'(out_cnt), exp_cnt[e]);
      chk(req, "entry last", int'(out_last), (e == n_exp - 1) ? 1 : 0);
      step();
    end
    chk(req, "no entry after last", int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  // R9: reset state, packets and ticks during the clearing sweep ignored
  task automatic t_reset_init();
    chk("R9", "out_valid in reset", int'(out_valid), 0);
    step();
    rst = 1'b0;
    chk("R9", "out_valid after reset", int'(out_valid), 0);
    pkt_valid = 1'b1;
    pkt_src = 3'd1;
    pkt_dst = 3'd2;
    repeat (3) step();
    pkt_valid = 1'b0;
    ign_tick();
    chk("R9", "out_valid during sweep", int'(out_valid), 0);
    repeat (NP + 5) step();
    tick(1'b0, 0, 0);
    drain(0, "R9");
  endtask

  // R1 R2 R5: mixed pairs, gaps and back-to-back, self pairs dropped
  task automatic t_basic();
    send(0, 1, 2);
    send(2, 5, 1);
    step();
    send(0, 1, 1);
    send(7, 6, 5);
    send(3, 3, 4);
    step();
    send(1, 0, 2);
    tick(1'b0, 0, 0);
    drain(0, "R1");
  endtask

  // R5: more than K pairs, equal counts ordered by pair index
  task automatic t_rank();
    send(4, 1, 2);
    send(1, 4, 2);
    send(2, 3, 2);
    send(0, 7, 2);
    send(5, 5, 9);
    send(6, 2, 1);
    tick(1'b0, 0, 0);
    drain(0, "R5");
  endtask

  // R3: saturation
  task automatic t_sat();
    send(5, 0, 20);
    send(0, 5, 14);
    tick(1'b0, 0, 0);
    drain(0, "R3");
  endtask

  // R7: latency from tick to first result
  task automatic t_timing();
    int cnt;
    send(3, 4, 1);
    tick(1'b0, 0, 0);
    out_ready = 1'b0;
    cnt = 0;
    while (!out_valid && cnt < NP + 20) begin
      step();
      cnt++;
    end
    chk("R7", "edges from tick to first result", cnt, NP + 1);
    drain(0, "R7");
  endtask

  // R4 R8: packet in tick cycle, ignored tick while busy
  task automatic t_boundary();
    send(1, 2, 2);
    tick(1'b1, 1, 2);
    ign_tick();
    send(6, 7, 3);
    drain(0, "R4");
    tick(1'b0, 0, 0);
    drain(0, "R8");
  endtask

  // R6: back-pressure
  task automatic t_backpressure();
    send(2, 1, 2);
    send(3, 1, 1);
    tick(1'b0, 0, 0);
    drain(5, "R6");
  endtask

  initial begin
    foreach (mdl[i]) mdl[i] = 0;
    foreach (snap[i]) snap[i] = 0;
    step();
    step();
    t_reset_init();
    t_basic();
    t_rank();
    t_sat();
    t_timing();
    t_boundary();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule